// File: doc/BRIEF.md
# Exception Vector Address Generator

This block turns a request to take an exception into the vector number for it and the memory address where the handler pointer lives. The caller gives the exception kind plus the details that pick the number: a trap immediate, the interrupt level with the outcome of the interrupt acknowledge, or the first opcode word and the current privilege. The block applies fixed internal numbering, opcode class decoding, autovectoring and a spurious fallback. It then adds four times the number to a loadable vector base. The base is a relocatable table pointer that clears on reset.

Results appear one clock after a request and are marked by a single-cycle valid pulse. Each result carries a tag that marks program space (only the two reset words) or data space. It also carries the decoded opcode class and the coprocessor number when the opcode addresses one. The block does not build stack frames, run bus cycles or fetch the vector contents.

Top module: `exc_vec_gen`

## Requirements
- R1: One clock after `req_i` is high, `vld_o` is high for one cycle and `vec_addr_o` equals the base in force at the request plus `vec_num_o` times four, with the offset zero-extended; without a request `vld_o` is low.
- R2: Kind 0 gives vector 0 and kind 1 gives vector 1, both with `prog_space_o`=1 and a base of zero. Every other kind gives `prog_space_o`=0.
- R3: The fixed kinds map as follows: kind 2 to 2, 3 to 3, 5 to 5, 6 to 6, 7 to 7, 8 to 8, 9 to 9, 10 to 14 and 11 to 15.
- R4: Kind 12 (explicit trap) gives vector 32 plus `trap_imm_i`, covering 32 to 47.
- R5: Kind 13 (interrupt) uses `iack_i`. Code 0 passes `dev_vec_i` through unchanged. Code 1 gives 24 plus `irq_lvl_i`. Codes 2 and 3 (acknowledge bus error) give the spurious vector 24.
- R6: Kind 4 (opcode fault) decodes `opcode_i`. If bits [15:12] are 0xA, the class is 2 (A-line) and the vector is 10. If bits [15:12] are 0xF and bits [11:9] are nonzero, the class is 4 (coprocessor), `cp_id_o` is bits [11:9] and the vector is 11.
- R7: Kind 4 with bits [15:12]=0xF and bits [11:9]=0 gives class 3 (F-line). The vector is 11 when `supervisor_i`=1 and 8 when `supervisor_i`=0.
- R8: Kind 4 with any other opcode gives class 1 (illegal) and vector 4. All kinds other than 4 give class 0 and `cp_id_o`=0.
- R9: The vector base is zero after `rst_ni` and loads `vbr_data_i` when `vbr_we_i` is high. A request in the same cycle still uses the old base. A kind 0 or 1 request clears the base, and this wins over a load in the same cycle.
- R10: While no request arrives, `vec_num_o`, `vec_addr_o`, `prog_space_o`, `opc_class_o` and `cp_id_o` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Exception request strobe |
| kind_i | input | 4 | Exception kind code |
| trap_imm_i | input | 4 | Explicit trap immediate |
| irq_lvl_i | input | 3 | Interrupt level being acknowledged |
| iack_i | input | 2 | Acknowledge outcome: 0 device, 1 autovector, 2/3 bus error |
| dev_vec_i | input | 8 | Vector byte supplied by the device |
| opcode_i | input | 16 | First opcode word of the faulting instruction |
| supervisor_i | input | 1 | Current privilege, 1 = supervisor |
| vbr_we_i | input | 1 | Vector base load strobe |
| vbr_data_i | input | AW | New vector base |
| vld_o | output | 1 | Result valid pulse |
| vec_num_o | output | 8 | Vector number |
| vec_addr_o | output | AW | Vector address |
| prog_space_o | output | 1 | 1 = program space, 0 = data space |
| opc_class_o | output | 3 | Opcode class: 0 none, 1 illegal, 2 A-line, 3 F-line, 4 coprocessor |
| cp_id_o | output | 3 | Addressed coprocessor number |

## Verification
A base load and an exception request can land in the same cycle. The bench drives a load together with a request and expects the address to be formed from the previous base, with the new base visible only on the following request. It also drives a load together with a reset-kind request and expects the base to read back as zero through the address of the next data-space request.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;
  localparam int unsigned VEC_W = 8;
  localparam int unsigned OFS_W = VEC_W + 2;

  typedef enum logic [3:0] {
    K_RST_SP   = 4'd0,
    K_RST_PC   = 4'd1,
    K_BUS_ERR  = 4'd2,
    K_ADR_ERR  = 4'd3,
    K_OPCODE   = 4'd4,
    K_ZDIV     = 4'd5,
    K_BOUNDS   = 4'd6,
    K_CTRAP    = 4'd7,
    K_PRIV     = 4'd8,
    K_TRACE    = 4'd9,
    K_FORMAT   = 4'd10,
    K_UNINIT   = 4'd11,
    K_TRAP     = 4'd12,
    K_IRQ      = 4'd13,
    K_RSVD14   = 4'd14,
    K_RSVD15   = 4'd15
  } exc_kind_e;

  typedef enum logic [2:0] {
    C_NONE    = 3'd0,
    C_ILLEGAL = 3'd1,
    C_ALINE   = 3'd2,
    C_FLINE   = 3'd3,
    C_COPROC  = 3'd4
  } opc_class_e;

  localparam logic [VEC_W-1:0] V_ILLEGAL  = 8'd4;
  localparam logic [VEC_W-1:0] V_PRIV     = 8'd8;
  localparam logic [VEC_W-1:0] V_ALINE    = 8'd10;
  localparam logic [VEC_W-1:0] V_FLINE    = 8'd11;
  localparam logic [VEC_W-1:0] V_FORMAT   = 8'd14;
  localparam logic [VEC_W-1:0] V_UNINIT   = 8'd15;
  localparam logic [VEC_W-1:0] V_SPURIOUS = 8'd24;
  localparam logic [VEC_W-1:0] V_TRAP0    = 8'd32;
endpackage

// File: rtl/exc_opcode_decode.sv
module exc_opcode_decode
  import exc_vec_pkg::*;
(
  input  logic [15:0]      opcode_i,
  input  logic             supervisor_i,
  output opc_class_e       cls_o,
  output logic [2:0]       cp_id_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [3:0] line;
  logic [2:0] cpid;
  assign line = opcode_i[15:12];
  assign cpid = opcode_i[11:9];

  always_comb begin
    cls_o   = C_ILLEGAL;
    cp_id_o = 3'd0;
    vec_o   = V_ILLEGAL;
    if (line == 4'hA) begin
      cls_o = C_ALINE;
      vec_o = V_ALINE;
    end else if (line == 4'hF) begin
      if (cpid != 3'd0) begin
        // no coprocessor answered: emulate through the F-line vector
        cls_o   = C_COPROC;
        cp_id_o = cpid;
        vec_o   = V_FLINE;
      end else begin
        cls_o = C_FLINE;
        vec_o = supervisor_i ? V_FLINE : V_PRIV;
      end
    end
  end
endmodule

// File: rtl/exc_vec_select.sv
module exc_vec_select
  import exc_vec_pkg::*;
(
  input  exc_kind_e        kind_i,
  input  logic [3:0]       trap_imm_i,
  input  logic [2:0]       irq_lvl_i,
  input  logic [1:0]       iack_i,
  input  logic [VEC_W-1:0] dev_vec_i,
  input  logic [VEC_W-1:0] dec_vec_i,
  output logic [VEC_W-1:0] vec_o,
  output logic             is_reset_o
);
  assign is_reset_o = (kind_i == K_RST_SP) || (kind_i == K_RST_PC);

  always_comb begin
    unique case (kind_i)
      K_RST_SP, K_RST_PC, K_BUS_ERR, K_ADR_ERR, K_ZDIV,
      K_BOUNDS, K_CTRAP, K_PRIV, K_TRACE:
                 vec_o = {4'd0, kind_i};
      K_OPCODE:  vec_o = dec_vec_i;
      K_FORMAT:  vec_o = V_FORMAT;
      K_UNINIT:  vec_o = V_UNINIT;
      K_TRAP:    vec_o = V_TRAP0 + {4'd0, trap_imm_i};
      K_IRQ: begin
        unique case (iack_i)
          2'd0:    vec_o = dev_vec_i;
          2'd1:    vec_o = V_SPURIOUS + {5'd0, irq_lvl_i};
          default: vec_o = V_SPURIOUS;
        endcase
      end
      default:   vec_o = V_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/exc_vbr.sv
module exc_vbr #(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] data_i,
  output logic [AW-1:0] vbr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vbr_o <= '0;
    else if (clr_i) vbr_o <= '0;
    else if (we_i)  vbr_o <= data_i;
  end
endmodule

// File: rtl/exc_vec_gen.sv
module exc_vec_gen
  import exc_vec_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [3:0]    kind_i,
  input  logic [3:0]    trap_imm_i,
  input  logic [2:0]    irq_lvl_i,
  input  logic [1:0]    iack_i,
  input  logic [7:0]    dev_vec_i,
  input  logic [15:0]   opcode_i,
  input  logic          supervisor_i,
  input  logic          vbr_we_i,
  input  logic [AW-1:0] vbr_data_i,
  output logic          vld_o,
  output logic [7:0]    vec_num_o,
  output logic [AW-1:0] vec_addr_o,
  output logic          prog_space_o,
  output logic [2:0]    opc_class_o,
  output logic [2:0]    cp_id_o
);
  localparam int unsigned PAD_W = AW - OFS_W;

  exc_kind_e        kind;
  opc_class_e       dec_cls;
  logic [2:0]       dec_cp;
  logic [VEC_W-1:0] dec_vec, sel_vec;
  logic             is_reset;
  logic [AW-1:0]    vbr_q, base, offset;

  assign kind = exc_kind_e'(kind_i);

  exc_opcode_decode i_dec (
    .opcode_i     (opcode_i),
    .supervisor_i (supervisor_i),
    .cls_o        (dec_cls),
    .cp_id_o      (dec_cp),
    .vec_o        (dec_vec)
  );

  exc_vec_select i_sel (
    .kind_i     (kind),
    .trap_imm_i (trap_imm_i),
    .irq_lvl_i  (irq_lvl_i),
    .iack_i     (iack_i),
    .dev_vec_i  (dev_vec_i),
    .dec_vec_i  (dec_vec),
    .vec_o      (sel_vec),
    .is_reset_o (is_reset)
  );

  exc_vbr #(.AW(AW)) i_vbr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (req_i && is_reset),
    .we_i   (vbr_we_i),
    .data_i (vbr_data_i),
    .vbr_o  (vbr_q)
  );

  // reset vectors live at the bottom of memory whatever the base held
  assign base   = is_reset ? '0 : vbr_q;
  assign offset = {{PAD_W{1'b0}}, sel_vec, 2'b00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o        <= 1'b0;
      vec_num_o    <= '0;
      vec_addr_o   <= '0;
      prog_space_o <= 1'b0;
      opc_class_o  <= C_NONE;
      cp_id_o      <= '0;
    end else begin
      vld_o <= req_i;
      if (req_i) begin
        vec_num_o    <= sel_vec;
        vec_addr_o   <= base + offset;
        prog_space_o <= is_reset;
        opc_class_o  <= (kind == K_OPCODE) ? dec_cls : C_NONE;
        cp_id_o      <= (kind == K_OPCODE) ? dec_cp : 3'd0;
      end
    end
  end
endmodule

// File: rtl/exc_vec_chk.sv
module exc_vec_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [3:0]    kind_i,
  input logic [15:0]   opcode_i,
  input logic [AW-1:0] vbr_q,
  input logic          vld_o,
  input logic [7:0]    vec_num_o,
  input logic [AW-1:0] vec_addr_o,
  input logic          prog_space_o,
  input logic [2:0]    opc_class_o,
  input logic [2:0]    cp_id_o
);
  logic rst_kind;
  assign rst_kind = (kind_i == 4'd0) || (kind_i == 4'd1);

  p_vld_follows_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vld_o);
  p_vld_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !vld_o);
  p_addr_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> vec_addr_o == ($past(rst_kind) ? {AW{1'b0}} : $past(vbr_q))
                           + {{(AW-10){1'b0}}, vec_num_o, 2'b00});
  p_prog_space_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> prog_space_o == (vec_num_o < 8'd2 && $past(rst_kind)));
  p_trap_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 4'd12) |=> vec_num_o[7:4] == 4'd2);
  p_vbr_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rst_kind) |=> vbr_q == '0);
  p_coproc_id_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && kind_i == 4'd4 && opcode_i[15:12] == 4'hF && opcode_i[11:9] != 3'd0)
    |=> (opc_class_o == 3'd4 && cp_id_o == $past(opcode_i[11:9])));
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(vec_num_o) && $stable(vec_addr_o) && $stable(opc_class_o)));
endmodule

bind exc_vec_gen exc_vec_chk #(.AW(AW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .kind_i       (kind_i),
  .opcode_i     (opcode_i),
  .vbr_q        (vbr_q),
  .vld_o        (vld_o),
  .vec_num_o    (vec_num_o),
  .vec_addr_o   (vec_addr_o),
  .prog_space_o (prog_space_o),
  .opc_class_o  (opc_class_o),
  .cp_id_o      (cp_id_o)
);

// File: tb/test_exc_vec_gen.sv
`timescale 1ns/1ps
module test_exc_vec_gen;
  localparam int unsigned AW = 32;

  typedef struct {
    logic [7:0]    vn;
    logic [AW-1:0] addr;
    logic          ps;
    logic [2:0]    cls;
    logic [2:0]    cp;
    string         tag;
  } exp_t;

  logic          clk_i = 1'b0, rst_ni = 1'b0, req_i = 1'b0;
  logic [3:0]    kind_i = '0, trap_imm_i = '0;
  logic [2:0]    irq_lvl_i = '0;
  logic [1:0]    iack_i = '0;
  logic [7:0]    dev_vec_i = '0;
  logic [15:0]   opcode_i = '0;
  logic          supervisor_i = 1'b1, vbr_we_i = 1'b0;
  logic [AW-1:0] vbr_data_i = '0;
  logic          vld_o, prog_space_o;
  logic [7:0]    vec_num_o;
  logic [AW-1:0] vec_addr_o;
  logic [2:0]    opc_class_o, cp_id_o;

  int checks = 0, errors = 0;
  bit done = 0;
  exp_t exp_q[$];
  exp_t last_exp;
  logic [AW-1:0] vbr_m = '0;

  always #4 clk_i = ~clk_i;

  exc_vec_gen #(.AW(AW)) i_exc_vec_gen (.*);

  // scoreboard monitor
  always @(posedge clk_i) begin
    #2;
    if (rst_ni && vld_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected valid vec=%0d expected none", vec_num_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        last_exp = e;
        if (vec_num_o !== e.vn || vec_addr_o !== e.addr || prog_space_o !== e.ps ||
            opc_class_o !== e.cls || cp_id_o !== e.cp) begin
          errors++;
          $display("FAIL %s got vec=%0d addr=%h ps=%0d cls=%0d cp=%0d exp vec=%0d addr=%h ps=%0d cls=%0d cp=%0d",
                   e.tag, vec_num_o, vec_addr_o, prog_space_o, opc_class_o, cp_id_o,
                   e.vn, e.addr, e.ps, e.cls, e.cp);
        end
      end
    end
  end

  task automatic issue(input logic [3:0] k, input logic [3:0] imm, input logic [2:0] lvl,
                       input logic [1:0] ack, input logic [7:0] dv, input logic [15:0] opc,
                       input logic sup, input logic we, input logic [AW-1:0] wd,
                       input logic [7:0] vn, input logic [2:0] cls, input logic [2:0] cp,
                       input string tag);
    exp_t e;
    logic rk;
    @(negedge clk_i);
    req_i = 1'b1; kind_i = k; trap_imm_i = imm; irq_lvl_i = lvl; iack_i = ack;
    dev_vec_i = dv; opcode_i = opc; supervisor_i = sup; vbr_we_i = we; vbr_data_i = wd;
    rk = (k == 4'd0 || k == 4'd1);
    e.vn = vn; e.cls = cls; e.cp = cp; e.tag = tag; e.ps = rk;
    e.addr = (rk ? '0 : vbr_m) + {22'd0, vn, 2'b00};
    exp_q.push_back(e);
    if (rk) vbr_m = '0;
    else if (we) vbr_m = wd;
  endtask

  task automatic simple(input logic [3:0] k, input logic [7:0] vn, input string tag);
    issue(k, 4'd0, 3'd0, 2'd0, 8'd0, 16'h0000, 1'b1, 1'b0, '0, vn, 3'd0, 3'd0, tag);
  endtask

  task automatic opc(input logic [15:0] o, input logic sup, input logic [7:0] vn,
                     input logic [2:0] cls, input logic [2:0] cp, input string tag);
    issue(4'd4, 4'd0, 3'd0, 2'd0, 8'd0, o, sup, 1'b0, '0, vn, cls, cp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      req_i = 1'b0; vbr_we_i = 1'b0;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (vld_o !== 1'b0 || vec_addr_o !== '0) begin
      errors++;
      $display("FAIL R9 reset state vld=%0d addr=%h exp vld=0 addr=0", vld_o, vec_addr_o);
    end
    rst_ni = 1'b1;
    idle(2);
    checks++;
    if (vld_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 valid without request got=%0d exp=0", vld_o);
    end

    // R2 reset words
    simple(4'd0, 8'd0, "R2 reset sp");
    simple(4'd1, 8'd1, "R2 reset pc");
    // R3 fixed
    simple(4'd2, 8'd2, "R3 bus err");
    simple(4'd3, 8'd3, "R3 addr err");
    simple(4'd5, 8'd5, "R3 zero div");
    simple(4'd6, 8'd6, "R3 bounds");
    simple(4'd7, 8'd7, "R3 cond trap");
    simple(4'd8, 8'd8, "R3 priv");
    simple(4'd9, 8'd9, "R3 trace");
    simple(4'd10, 8'd14, "R3 format");
    simple(4'd11, 8'd15, "R3 uninit irq");
    // R4 traps
    issue(4'd12, 4'd0, 3'd0, 2'd0, 8'd0, 16'h0, 1'b1, 1'b0, '0, 8'd32, 3'd0, 3'd0, "R4 trap 0");
    issue(4'd12, 4'd15, 3'd0, 2'd0, 8'd0, 16'h0, 1'b1, 1'b0, '0, 8'd47, 3'd0, 3'd0, "R4 trap 15");
    // R5 interrupts
    issue(4'd13, 4'd0, 3'd5, 2'd0, 8'hC3, 16'h0, 1'b1, 1'b0, '0, 8'hC3, 3'd0, 3'd0, "R5 device vec");
    for (int l = 1; l < 8; l++)
      issue(4'd13, 4'd0, 3'(l), 2'd1, 8'hEE, 16'h0, 1'b1, 1'b0, '0, 8'(24 + l), 3'd0, 3'd0, "R5 autovector");
    issue(4'd13, 4'd0, 3'd4, 2'd2, 8'hEE, 16'h0, 1'b1, 1'b0, '0, 8'd24, 3'd0, 3'd0, "R5 spurious");
    issue(4'd13, 4'd0, 3'd6, 2'd3, 8'hEE, 16'h0, 1'b1, 1'b0, '0, 8'd24, 3'd0, 3'd0, "R5 spurious code3");
    // R6/R7/R8 opcode decode
    opc(16'hA123, 1'b0, 8'd10, 3'd2, 3'd0, "R6 a-line");
    opc(16'hFA00, 1'b1, 8'd11, 3'd4, 3'd5, "R6 coprocessor 5");
    opc(16'hFE00, 1'b0, 8'd11, 3'd4, 3'd7, "R6 coprocessor 7");
    opc(16'hF1FF, 1'b1, 8'd11, 3'd3, 3'd0, "R7 f-line supervisor");
    opc(16'hF1FF, 1'b0, 8'd8, 3'd3, 3'd0, "R7 f-line user");
    opc(16'h4AFC, 1'b1, 8'd4, 3'd1, 3'd0, "R8 illegal");
    opc(16'hE000, 1'b0, 8'd4, 3'd1, 3'd0, "R8 illegal other line");
    // R9 load with simultaneous request: old base used
    issue(4'd9, 4'd0, 3'd0, 2'd0, 8'd0, 16'h0, 1'b1, 1'b1, 32'h0000_1000, 8'd9, 3'd0, 3'd0, "R9 load same cycle old base");
    simple(4'd2, 8'd2, "R9 new base applied");
    issue(4'd12, 4'd3, 3'd0, 2'd0, 8'd0, 16'h0, 1'b1, 1'b0, '0, 8'd35, 3'd0, 3'd0, "R1 relocated trap");
    simple(4'd1, 8'd1, "R2 reset pc ignores base");
    simple(4'd5, 8'd5, "R9 base cleared by reset kind");
    // reset kind wins over load
    idle(1);
    issue(4'd3, 4'd0, 3'd0, 2'd0, 8'd0, 16'h0, 1'b1, 1'b1, 32'h0000_2000, 8'd3, 3'd0, 3'd0, "R9 load");
    issue(4'd0, 4'd0, 3'd0, 2'd0, 8'd0, 16'h0, 1'b1, 1'b1, 32'h0000_3000, 8'd0, 3'd0, 3'd0, "R9 reset with load");
    simple(4'd8, 8'd8, "R9 reset beats load");
    idle(4);

    // R10 hold
    checks++;
    if (vec_num_o !== last_exp.vn || vec_addr_o !== last_exp.addr || opc_class_o !== last_exp.cls) begin
      errors++;
      $display("FAIL R10 hold vec=%0d addr=%h exp vec=%0d addr=%h",
               vec_num_o, vec_addr_o, last_exp.vn, last_exp.addr);
    end
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 missing results got=%0d pending exp=0", exp_q.size());
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule